// File: doc/BRIEF.md
# TDM receive time-slot demultiplexer

This block sits behind a serial time-division-multiplexed receive line. One bit arrives on every clock while the block is enabled. A frame-sync pulse marks the first bit of a frame. The block walks a 64-entry slot table in step with the line. Each entry covers one 8-bit slot and states four things: whether the slot carries data, whether the slot is the last one in the frame, which logical channel owns the slot, and which of the slot's eight bit positions belong to that channel.

Every bit that a valid entry keeps is presented in the same cycle it arrives. It comes out with its position inside the slot, a 12-bit channel base address and a strobe, so that a per-channel consumer downstream can accumulate it. Bits that are discarded produce no strobe, so the consumer's bit count does not advance for them. Software loads the table through a simple write port while the block is disabled. A write that would address beyond the 2 KB parameter space is reported.

Top module: `tdm_rx_slot_demux`

## Requirements
- R1: A table word is laid out as bit 15 = slot valid, bit 14 = last slot of frame, bits 13:8 = channel pointer, bits 7:0 = keep mask. Mask bit (7 - p) governs bit position p of the slot.
- R2: A table write takes effect only when `wr_en` is high while `enable` is low. A write attempted while `enable` is high leaves the table unchanged.
- R3: `wr_err` is high for exactly the one cycle after an accepted write whose bit 13 (pointer MSB) is 1, and is low otherwise.
- R4: The cycle in which `fsync` is high carries slot 0, bit position 0. Later bits take positions 1 to 7 in arrival order (MSB first), and then the next slot begins at position 0.
- R5: A bit in a slot whose entry has the valid flag at 0 raises no strobe.
- R6: In a valid slot, a bit whose mask bit is 1 raises `out_valid` in its own cycle, with `out_bit` equal to `rx_bit` and `out_pos` equal to its position. A bit whose mask bit is 0 raises no strobe.
- R7: With `out_valid` high, `out_base` equals the entry's 6-bit pointer followed by six zero bits.
- R8: After position 7 of an entry with the last-slot flag set, no strobe is raised until the next `fsync`, which restarts at entry 0.
- R9: An `fsync` that arrives while a frame is still in progress (no last-slot entry finished yet) restarts at entry 0 in that cycle and sets `sync_err`. `sync_err` is cleared only by reset.
- R10: While `enable` is low, no strobe is raised and any frame in progress is dropped. After `enable` rises, nothing is delivered until an `fsync` arrives.
- R11: If no entry carries the last-slot flag, the slot after entry 63 is entry 0.
- R12: After reset, `out_valid`, `wr_err` and `sync_err` are low and every table entry reads as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Receive enable; table writes are accepted only when low |
| fsync | input | 1 | Frame-sync pulse, high during the first bit of a frame |
| rx_bit | input | 1 | Serial receive data |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 6 | Table entry index |
| wr_data | input | 16 | Table word (layout in R1) |
| wr_err | output | 1 | One-cycle flag: accepted write had the pointer MSB set |
| out_valid | output | 1 | Delivered-bit strobe |
| out_bit | output | 1 | Delivered bit value |
| out_pos | output | 3 | Position of the delivered bit within its slot |
| out_base | output | 12 | Channel base address of the delivered bit |
| sync_err | output | 1 | Sticky flag: frame sync arrived mid-frame |

## Verification
The properties assume that the table changes only while `enable` is low. They also assume that `fsync` is sampled in the same cycle as the bit it marks, so a strobe in an `fsync` cycle must carry position 0. The stimulus loads every table image with `enable` low. Its one write during operation is made deliberately, to show that such a write is dropped. The stimulus raises `fsync` on whole cycles only, and it covers on-time frames, idle gaps after the last slot, an early sync, a sync while disabled, and a full 64-entry walk without a last-slot flag.

// File: rtl/tsd_pkg.sv
// Shared field widths and the table-entry record of the slot demultiplexer.
// Assumes: a slot is always 8 bits wide; the pointer field is 6 bits.
package tsd_pkg;
    localparam int PTR_W   = 6;
    localparam int MASK_W  = 8;
    localparam int ENTRY_W = 2 + PTR_W + MASK_W;
    localparam int POS_W   = $clog2(MASK_W);
    localparam int BASE_W  = 12;
    localparam int ZERO_W  = BASE_W - PTR_W;

    typedef struct packed {
        logic              valid;
        logic              last;
        logic [PTR_W-1:0]  ptr;
        logic [MASK_W-1:0] keep;
    } tsd_entry_t;
endpackage

// File: rtl/tsd_table.sv
// Slot table: DEPTH entries in flops, one synchronous write port, one
// asynchronous read port. Writes are dropped while `lock` is high. A write
// accepted with the pointer MSB set raises `wr_err` in the next cycle.
// Assumes: DEPTH is a power of two.
module tsd_table
    import tsd_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  tsd_entry_t    wr_entry,
    input  logic [AW-1:0] rd_idx,
    output tsd_entry_t    rd_entry,
    output logic          wr_err
);
    tsd_entry_t mem [DEPTH];
    logic       wr_ok;

    // Accept a write only when the sequencer is stopped.
    assign wr_ok = wr_en && !lock;

    // Store entries; reset clears every entry to invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_ok) begin
            mem[wr_addr] <= wr_entry;
        end
    end

    // Flag an accepted write whose pointer reaches past the 2 KB space.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= wr_ok && wr_entry.ptr[PTR_W-1];
    end

    // Read the entry for the slot on the line this cycle.
    assign rd_entry = mem[rd_idx];
endmodule

// File: rtl/tsd_seq.sv
// Slot and bit sequencer. It tracks the entry index and bit position of the
// bit on the line. Frame sync forces entry 0, position 0 in its own cycle.
// After the last bit of an entry flagged `last`, the sequencer idles until
// the next frame sync. A sync seen mid-frame sets a sticky error.
// Assumes: `entry_last` is the flag of the entry at `cur_idx`.
module tsd_seq
    import tsd_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fsync,
    input  logic             entry_last,
    output logic [AW-1:0]    cur_idx,
    output logic [POS_W-1:0] cur_pos,
    output logic             cur_act,
    output logic             sync_err
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(MASK_W - 1);

    logic             running;
    logic [AW-1:0]    idx_q;
    logic [POS_W-1:0] pos_q;

    // Effective position this cycle: a frame sync overrides the counters.
    always_comb begin
        cur_act = enable && (fsync || running);
        cur_idx = fsync ? '0 : idx_q;
        cur_pos = fsync ? '0 : pos_q;
    end

    // Advance the bit and slot counters, and stop after a last-slot entry.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            running <= 1'b0;
            idx_q   <= '0;
            pos_q   <= '0;
        end else if (cur_act) begin
            if (cur_pos == POS_LAST) begin
                pos_q   <= '0;
                running <= !entry_last;
                idx_q   <= entry_last ? '0 : cur_idx + 1'b1;
            end else begin
                pos_q   <= cur_pos + 1'b1;
                idx_q   <= cur_idx;
                running <= 1'b1;
            end
        end
    end

    // Record a frame sync that lands inside an unfinished frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                          sync_err <= 1'b0;
        else if (enable && fsync && running) sync_err <= 1'b1;
    end
endmodule

// File: rtl/tsd_emit.sv
// Bit selector. It applies the valid flag and the keep mask of the current
// entry, and forms the delivered bit, its position and the channel base
// address. Purely combinational, so a bit leaves in its arrival cycle.
// Assumes: mask bit (MASK_W-1-p) belongs to bit position p.
module tsd_emit
    import tsd_pkg::*;
(
    input  logic              act,
    input  tsd_entry_t        entry,
    input  logic [POS_W-1:0]  pos,
    input  logic              rx_bit,
    output logic              out_valid,
    output logic              out_bit,
    output logic [POS_W-1:0]  out_pos,
    output logic [BASE_W-1:0] out_base
);
    logic keep_bit;

    // Pick the mask bit for this position (first bit uses the mask MSB).
    assign keep_bit = entry.keep[POS_W'(MASK_W - 1) - pos];

    // Drive the strobe and its payload.
    always_comb begin
        out_valid = act && entry.valid && keep_bit;
        out_bit   = rx_bit;
        out_pos   = pos;
        out_base  = {entry.ptr, {ZERO_W{1'b0}}};
    end
endmodule

// File: rtl/tdm_rx_slot_demux.sv
// Top of the TDM receive slot demultiplexer: table, sequencer and bit
// selector. One line bit per clock. Table writes are accepted only while
// `enable` is low.
// Assumes: DEPTH is a power of two; fsync is high during the first bit.
module tdm_rx_slot_demux
    import tsd_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fsync,
    input  logic              rx_bit,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic              wr_err,
    output logic              out_valid,
    output logic              out_bit,
    output logic [POS_W-1:0]  out_pos,
    output logic [BASE_W-1:0] out_base,
    output logic              sync_err
);
    tsd_entry_t       entry;
    logic [AW-1:0]    idx;
    logic [POS_W-1:0] pos;
    logic             act;

    tsd_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (enable),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_entry (tsd_entry_t'(wr_data)),
        .rd_idx   (idx),
        .rd_entry (entry),
        .wr_err   (wr_err)
    );

    tsd_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .fsync      (fsync),
        .entry_last (entry.last),
        .cur_idx    (idx),
        .cur_pos    (pos),
        .cur_act    (act),
        .sync_err   (sync_err)
    );

    tsd_emit u_emit (
        .act       (act),
        .entry     (entry),
        .pos       (pos),
        .rx_bit    (rx_bit),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_pos   (out_pos),
        .out_base  (out_base)
    );
endmodule

// File: rtl/tsd_checker.sv
// Port-level properties of the slot demultiplexer, bound to every instance.
module tsd_checker
    import tsd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              fsync,
    input logic              rx_bit,
    input logic              wr_en,
    input logic              wr_err,
    input logic              out_valid,
    input logic              out_bit,
    input logic [POS_W-1:0]  out_pos,
    input logic [BASE_W-1:0] out_base,
    input logic              sync_err
);
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !enable |-> !out_valid); // R10
    AST_SYNC_AT_POS0: assert property (@(posedge clk) disable iff (!rst_n) (fsync && out_valid) |-> (out_pos == '0)); // R4
    AST_BIT_PASSES: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_bit == rx_bit)); // R6
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_base[ZERO_W-1:0] == '0)); // R7
    AST_WRERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) wr_err |-> $past(wr_en && !enable)); // R3
    AST_WRERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wr_err |=> !wr_err || $past(wr_en && !enable)); // R3
    AST_SYNCERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) sync_err |=> sync_err); // R9
endmodule

bind tdm_rx_slot_demux tsd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .fsync     (fsync),
    .rx_bit    (rx_bit),
    .wr_en     (wr_en),
    .wr_err    (wr_err),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_pos   (out_pos),
    .out_base  (out_base),
    .sync_err  (sync_err)
);

// File: tb/sim_tdm_rx_slot_demux.sv
// Bench: behavioural reference model stepped once per clock and compared
// with the outputs every cycle.
module sim_tdm_rx_slot_demux;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        fsync = 1'b0;
    logic        rx_bit = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_err;
    logic        out_valid;
    logic        out_bit;
    logic [2:0]  out_pos;
    logic [11:0] out_base;
    logic        sync_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R12";

    // Reference model state.
    logic [15:0] m_tab [64];
    bit m_run = 0;
    int m_slot = 0;
    int m_pos = 0;
    bit m_serr = 0;
    bit m_werr = 0;

    tdm_rx_slot_demux u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fsync(fsync), .rx_bit(rx_bit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
        .out_valid(out_valid), .out_bit(out_bit), .out_pos(out_pos),
        .out_base(out_base), .sync_err(sync_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, compare against the model, then advance it.
    task automatic step(input bit en, input bit fs, input bit rb,
                        input bit we, input int wa, input int wd);
        bit act;
        int idx, pos;
        logic [15:0] e;
        bit exp_v;
        @(negedge clk);
        enable = en; fsync = fs; rx_bit = rb;
        wr_en = we; wr_addr = 6'(wa); wr_data = 16'(wd);
        #1;
        act = en && (fs || m_run);
        idx = fs ? 0 : m_slot;
        pos = fs ? 0 : m_pos;
        e = m_tab[idx];
        exp_v = act && e[15] && e[7 - pos];          // R1 R5 R6 R8 R10
        check(tag, "out_valid", int'(out_valid), int'(exp_v));
        if (exp_v) begin
            check("R6", "out_bit", int'(out_bit), int'(rb));
            check("R4", "out_pos", int'(out_pos), pos);
            check("R7", "out_base", int'(out_base), int'({e[13:8], 6'b0}));
        end
        check("R3", "wr_err", int'(wr_err), int'(m_werr));
        check("R9", "sync_err", int'(sync_err), int'(m_serr));
        // Advance the model to the next cycle.
        m_werr = we && !en && wd[13];
        if (we && !en) m_tab[wa] = 16'(wd);        // R2
        if (!en) begin
            m_run = 0; m_slot = 0; m_pos = 0;
        end else begin
            if (fs && m_run) m_serr = 1;             // R9
            if (act) begin
                if (pos == 7) begin
                    m_pos = 0;
                    if (e[14]) begin m_run = 0; m_slot = 0; end
                    else begin m_run = 1; m_slot = (idx + 1) % 64; end  // R11
                end else begin
                    m_pos = pos + 1; m_slot = idx; m_run = 1;
                end
            end
        end
    endtask

    task automatic bits(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 1'($urandom), 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_tab[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check("R12", "out_valid", int'(out_valid), 0);
        check("R12", "wr_err", int'(wr_err), 0);
        check("R12", "sync_err", int'(sync_err), 0);
        rst_n = 1'b1;

        // R12: empty table delivers nothing even on a frame.
        tag = "R12";
        step(1, 1, 1, 0, 0, 0); bits(15);
        step(0, 0, 0, 0, 0, 0);

        // R1 R3: load table; entry 10 has pointer MSB set.
        tag = "R1";
        step(0, 0, 0, 1, 0, 16'h85FF);   // valid, ptr 5, full mask
        step(0, 0, 0, 1, 1, 16'h0A3C);   // invalid slot
        step(0, 0, 0, 1, 2, 16'h9FA5);   // valid, ptr 0x1F, sparse mask
        step(0, 0, 0, 1, 10, 16'hA0FF);  // R3: pointer MSB set
        step(0, 0, 0, 1, 3, 16'hC2FF);   // valid, last, ptr 2
        step(0, 0, 0, 0, 0, 0);

        // R10: enabled but no sync yet: nothing delivered.
        tag = "R10";
        bits(10);

        // R4 R5 R6 R7 R8: a full frame, then idle after the last slot.
        tag = "R5";
        step(1, 1, 1, 0, 0, 0); bits(31);
        tag = "R8";
        bits(12);
        tag = "R6";
        step(1, 1, 0, 0, 0, 0); bits(31);
        tag = "R8";
        bits(5);

        // R9: early sync in slot 1 restarts at entry 0.
        tag = "R9";
        step(1, 1, 1, 0, 0, 0); bits(13);
        step(1, 1, 1, 0, 0, 0); bits(40);

        // R2: write while enabled is dropped; frame must still use old entry 0.
        tag = "R2";
        step(1, 0, 0, 1, 0, 16'h0000);
        step(1, 1, 1, 0, 0, 0); bits(31);

        // R10: sync while disabled delivers nothing, then enable without sync.
        tag = "R10";
        step(0, 1, 1, 0, 0, 0);
        for (int i = 0; i < 7; i++) step(0, 0, 1, 0, 0, 0);
        bits(9);
        step(0, 0, 0, 0, 0, 0);

        // R11: table without any last-slot flag; walk past entry 63.
        tag = "R11";
        for (int i = 0; i < 64; i++)
            step(0, 0, 0, 1, i, 16'h8000 | ((i % 32) << 8) | ((i * 37 + 1) & 8'hFF));
        step(1, 1, 1, 0, 0, 0); bits(64 * 8 + 40);
        step(0, 0, 0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule